// File: doc/BRIEF.md
# Time-Aware Egress Gate Scheduler

This block opens and closes the eight per-class transmit gates of one egress port according to a cyclic gate control list. Each list entry holds an 8-bit gate mask and an interval in nanoseconds. Bit i of the mask belongs to traffic class i, and a 1 means that the class may transmit. The block watches a free-running, externally synchronized nanosecond time input. It starts the list at a programmed absolute base time and walks through the entries. When the last entry ends, it returns to the first. All gate events fall on a 200 ns slot grid, and every interval is rounded up to whole slots.

Software writes entries into a shadow table and then commits the table together with an entry count, a base time and a cycle time. The commit is validated at once and is either rejected or parked as pending. A pending list goes live immediately if no schedule is running. Otherwise it goes live at the next cycle boundary, so a running cycle is never cut short. A one-clock pulse marks every entry start. The block compares that pulse against a peer-event input, fed from the other scheduled ports, to flag two gate events that share a slot. It only reports such a conflict and does not resolve it.

Top module: `tas_gate_sched`

## Requirements
- R1: While reset is held and after its release, `gateOpen` is all ones and `entryPulse`, `cfgReject` and `schedConflict` are low.
- R2: Before any list is live, and before the base time of a newly armed list, all gates stay open and no entry pulse occurs. Entry 0 starts on the first clock whose sampled `syncTime` is at or past the base time.
- R3: An entry with interval I ns holds its mask for ceil(I/200) slots. The next entry starts exactly 200*ceil(I/200) ns after it, so for example 1900 ns lasts 10 slots and 150 ns lasts 1 slot.
- R4: After the last of the N committed entries ends, entry 0 starts again and the list repeats without a gap.
- R5: `entryPulse` is high for exactly one clock at every entry start, including wrap-around, and low on every other clock.
- R6: A commit is rejected, with `cfgReject` high on the clock after it, if any of these holds: the count is 0, the count exceeds MAX_ENTRIES, any entry below the count rounds to zero slots, or the sum of their slots differs from ceil(cycle time/200). A rejected commit leaves the running schedule unchanged.
- R7: A list accepted while a schedule runs takes effect only when the current cycle's last entry ends. Its entry 0 starts at that boundary, and its base time is ignored.
- R8: While an accepted list is still pending, shadow writes are ignored and further commits are rejected.
- R9: `schedConflict` is high on the clock after a clock where `entryPulse` and `peerEvent` are both high, and low otherwise.
- R10: `syncTime` may advance by less than one slot per clock. Entry starts still occur only at base + k*200 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncTime | input | TIME_W | Synchronized time in ns |
| cfgWrEn | input | 1 | Shadow entry write strobe |
| cfgWrIdx | input | IDX_W | Shadow entry index |
| cfgWrMask | input | NUM_TC | Gate mask, bit i = class i, 1 = open |
| cfgWrInterval | input | IVAL_W | Entry interval in ns |
| cfgCommit | input | 1 | Commit shadow list strobe |
| cfgNumEntries | input | CNT_W | Entry count for the commit |
| cfgBaseTime | input | TIME_W | Absolute start time for the commit |
| cfgCycleTime | input | IVAL_W | Cycle length in ns for the commit |
| peerEvent | input | 1 | Gate event pulse from other scheduled ports |
| gateOpen | output | NUM_TC | Per-class gate open vector |
| entryPulse | output | 1 | One-clock pulse at each entry start |
| cfgReject | output | 1 | Commit rejected, one clock after the commit |
| schedConflict | output | 1 | Own and peer gate events in the same slot |

## Verification
Two pairs of functions can meet on the same clock. The first pair is an entry start and a peer event. The bench raises `peerEvent` on the clock where a scheduled entry begins, then again one half-slot later, and expects a conflict flag only for the first. The second pair is the end of a cycle and the swap to a pending list. The bench commits mid-cycle and then tries a shadow write and a second commit while the list is pending. The scoreboard requires the old list to finish its cycle unaltered and the new list to start precisely at the boundary with the unmodified entries.

// File: rtl/tas_pkg.sv
package tas_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } schedState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shadowWrite;
    logic acceptCommit;
    logic swapIn;
    logic arm;
    logic stepSlot;
    logic enterEntry;
    logic wrapList;
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic tick;
    logic lastEntry;
    logic lastSlot;
    logic commitOk;
  } dpStatus_t;

endpackage

// File: rtl/tas_gate_datapath.sv
module tas_gate_datapath
  import tas_pkg::*;
#(
  parameter int NUM_TC      = 8,
  parameter int MAX_ENTRIES = 8,
  parameter int TIME_W      = 64,
  parameter int IVAL_W      = 32,
  parameter int SLOT_NS     = 200,
  localparam int IDX_W = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1,
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] syncTime,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [NUM_TC-1:0] wrMask,
  input  logic [IVAL_W-1:0] wrInterval,
  input  logic [CNT_W-1:0]  numEntries,
  input  logic [TIME_W-1:0] baseTime,
  input  logic [IVAL_W-1:0] cycleTime,
  input  ctrlStrobe_t       strobe,
  output dpStatus_t         status,
  output logic [NUM_TC-1:0] gateOpen,
  output logic              entryPulse
);

  localparam int SUM_W = IVAL_W + CNT_W;

  function automatic logic [IVAL_W-1:0] toSlots(input logic [IVAL_W-1:0] ns);
    logic [IVAL_W:0] wide;
    wide = {1'b0, ns} + (IVAL_W+1)'(SLOT_NS - 1);
    return IVAL_W'(wide / (IVAL_W+1)'(SLOT_NS));
  endfunction

  logic [NUM_TC-1:0] shMask   [MAX_ENTRIES];
  logic [IVAL_W-1:0] shSlots  [MAX_ENTRIES];
  logic [NUM_TC-1:0] actMask  [MAX_ENTRIES];
  logic [IVAL_W-1:0] actSlots [MAX_ENTRIES];
  logic [CNT_W-1:0]  pendCount, actCount;
  logic [TIME_W-1:0] pendBase, nextEdge;
  logic [IDX_W-1:0]  curIdx, nextIdx;
  logic [IVAL_W-1:0] remaining, nextSlots;
  logic [NUM_TC-1:0] nextMask;
  logic [SUM_W-1:0]  sumSlots;
  logic              zeroSeen, countOk;

  // commit validation over the shadow table
  always_comb begin
    sumSlots = '0;
    zeroSeen = 1'b0;
    for (int i = 0; i < MAX_ENTRIES; i++) begin
      if (CNT_W'(i) < numEntries) begin
        sumSlots = sumSlots + SUM_W'(shSlots[i]);
        if (shSlots[i] == '0) zeroSeen = 1'b1;
      end
    end
    countOk = (numEntries != '0) && (numEntries <= CNT_W'(MAX_ENTRIES));
  end

  // next entry selection, from the shadow table when it is swapped in
  always_comb begin
    nextIdx = strobe.wrapList ? '0 : curIdx + 1'b1;
    if (strobe.swapIn) begin
      nextMask  = shMask[nextIdx];
      nextSlots = shSlots[nextIdx];
    end else begin
      nextMask  = actMask[nextIdx];
      nextSlots = actSlots[nextIdx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MAX_ENTRIES; i++) begin
        shMask[i]   <= '0;
        shSlots[i]  <= '0;
        actMask[i]  <= '0;
        actSlots[i] <= '0;
      end
      pendCount  <= '0;
      actCount   <= '0;
      pendBase   <= '0;
      nextEdge   <= '0;
      curIdx     <= '0;
      remaining  <= '0;
      gateOpen   <= '1;
      entryPulse <= 1'b0;
    end else begin
      entryPulse <= strobe.enterEntry;
      if (strobe.shadowWrite && (CNT_W'(wrIdx) < CNT_W'(MAX_ENTRIES))) begin
        shMask[wrIdx]  <= wrMask;
        shSlots[wrIdx] <= toSlots(wrInterval);
      end
      if (strobe.acceptCommit) begin
        pendCount <= numEntries;
        pendBase  <= baseTime;
      end
      if (strobe.swapIn) begin
        for (int i = 0; i < MAX_ENTRIES; i++) begin
          actMask[i]  <= shMask[i];
          actSlots[i] <= shSlots[i];
        end
        actCount <= pendCount;
      end
      if (strobe.arm) nextEdge <= pendBase;
      else if (strobe.stepSlot) nextEdge <= nextEdge + TIME_W'(SLOT_NS);
      if (strobe.enterEntry) begin
        curIdx    <= nextIdx;
        remaining <= nextSlots;
        gateOpen  <= nextMask;
      end else if (strobe.stepSlot) begin
        remaining <= remaining - 1'b1;
      end
    end
  end

  assign status.tick      = (syncTime >= nextEdge);
  assign status.lastEntry = (CNT_W'(curIdx) == actCount - 1'b1);
  assign status.lastSlot  = (remaining == IVAL_W'(1));
  assign status.commitOk  = countOk && !zeroSeen && (sumSlots == SUM_W'(toSlots(cycleTime)));

  // R3: a started entry always carries a non-empty interval
  assert_entry_has_slots_R3: assert property (@(posedge clk) disable iff (!rstN)
    entryPulse |-> (remaining != '0));

  // R4: a wrap request from control lands on entry 0
  assert_wrap_restarts_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.enterEntry && strobe.wrapList) |=> (curIdx == '0));

  // R5: the gate vector only moves together with an entry pulse
  assert_gate_moves_with_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    !entryPulse |-> $stable(gateOpen));

endmodule

// File: rtl/tas_gate_control.sv
module tas_gate_control
  import tas_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        commit,
  input  logic        peerEvent,
  input  logic        entryPulse,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        cfgReject,
  output logic        schedConflict
);

  schedState_t state, stateNext;
  logic        pending;

  always_comb begin
    strobe              = '0;
    stateNext           = state;
    strobe.shadowWrite  = wrEn && !pending;
    strobe.acceptCommit = commit && !pending && status.commitOk;
    case (state)
      ST_IDLE: begin
        if (pending) begin
          strobe.swapIn = 1'b1;
          strobe.arm    = 1'b1;
          stateNext     = ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (pending) begin
          strobe.swapIn = 1'b1;
          strobe.arm    = 1'b1;
        end else if (status.tick) begin
          strobe.stepSlot   = 1'b1;
          strobe.enterEntry = 1'b1;
          strobe.wrapList   = 1'b1;
          stateNext         = ST_RUN;
        end
      end
      ST_RUN: begin
        if (status.tick) begin
          strobe.stepSlot = 1'b1;
          if (status.lastSlot) begin
            strobe.enterEntry = 1'b1;
            if (status.lastEntry) begin
              strobe.wrapList = 1'b1;
              strobe.swapIn   = pending;
            end
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state         <= ST_IDLE;
      pending       <= 1'b0;
      cfgReject     <= 1'b0;
      schedConflict <= 1'b0;
    end else begin
      state         <= stateNext;
      pending       <= (pending && !strobe.swapIn) || strobe.acceptCommit;
      cfgReject     <= commit && !strobe.acceptCommit;
      schedConflict <= entryPulse && peerEvent;
    end
  end

  // R6: a reject only ever answers a commit
  assert_reject_follows_commit_R6: assert property (@(posedge clk) disable iff (!rstN)
    cfgReject |-> $past(commit));

  // R2: no entry starts while no list has been armed
  assert_quiet_before_list_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !entryPulse);

  // R9: a conflict needs an own gate event in the clock before
  assert_conflict_has_event_R9: assert property (@(posedge clk) disable iff (!rstN)
    schedConflict |-> $past(entryPulse));

endmodule

// File: rtl/tas_gate_sched.sv
module tas_gate_sched
  import tas_pkg::*;
#(
  parameter int NUM_TC      = 8,
  parameter int MAX_ENTRIES = 8,
  parameter int TIME_W      = 64,
  parameter int IVAL_W      = 32,
  parameter int SLOT_NS     = 200,
  localparam int IDX_W = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1,
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] syncTime,
  input  logic              cfgWrEn,
  input  logic [IDX_W-1:0]  cfgWrIdx,
  input  logic [NUM_TC-1:0] cfgWrMask,
  input  logic [IVAL_W-1:0] cfgWrInterval,
  input  logic              cfgCommit,
  input  logic [CNT_W-1:0]  cfgNumEntries,
  input  logic [TIME_W-1:0] cfgBaseTime,
  input  logic [IVAL_W-1:0] cfgCycleTime,
  input  logic              peerEvent,
  output logic [NUM_TC-1:0] gateOpen,
  output logic              entryPulse,
  output logic              cfgReject,
  output logic              schedConflict
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  tas_gate_control u_control (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (cfgWrEn),
    .commit       (cfgCommit),
    .peerEvent    (peerEvent),
    .entryPulse   (entryPulse),
    .status       (status),
    .strobe       (strobe),
    .cfgReject    (cfgReject),
    .schedConflict(schedConflict)
  );

  tas_gate_datapath #(
    .NUM_TC     (NUM_TC),
    .MAX_ENTRIES(MAX_ENTRIES),
    .TIME_W     (TIME_W),
    .IVAL_W     (IVAL_W),
    .SLOT_NS    (SLOT_NS)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .syncTime   (syncTime),
    .wrIdx      (cfgWrIdx),
    .wrMask     (cfgWrMask),
    .wrInterval (cfgWrInterval),
    .numEntries (cfgNumEntries),
    .baseTime   (cfgBaseTime),
    .cycleTime  (cfgCycleTime),
    .strobe     (strobe),
    .status     (status),
    .gateOpen   (gateOpen),
    .entryPulse (entryPulse)
  );

endmodule

// File: tb/tas_gate_sched_bench.sv
module tas_gate_sched_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [63:0] t;
    logic [7:0]  m;
  } evt_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] syncTime = 64'd5_000_000_000;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgWrIdx = '0;
  logic [7:0]  cfgWrMask = '0;
  logic [31:0] cfgWrInterval = '0;
  logic        cfgCommit = 1'b0;
  logic [3:0]  cfgNumEntries = '0;
  logic [63:0] cfgBaseTime = '0;
  logic [31:0] cfgCycleTime = '0;
  logic        peerEvent = 1'b0;
  logic [7:0]  gateOpen;
  logic        entryPulse;
  logic        cfgReject;
  logic        schedConflict;

  evt_t        expQ[$];
  int          checks = 0;
  int          fails = 0;
  logic [63:0] step = 64'd200;
  logic [7:0]  curMask = 8'hFF;
  logic        conflictExp = 1'b0;
  logic        monitorOn = 1'b0;
  logic        hit;
  logic [63:0] peerA = '1;
  logic [63:0] peerB = '1;
  logic [63:0] baseT, swapT;

  tas_gate_sched u_tas_gate_sched (
    .clk(clk), .rstN(rstN), .syncTime(syncTime),
    .cfgWrEn(cfgWrEn), .cfgWrIdx(cfgWrIdx), .cfgWrMask(cfgWrMask),
    .cfgWrInterval(cfgWrInterval), .cfgCommit(cfgCommit),
    .cfgNumEntries(cfgNumEntries), .cfgBaseTime(cfgBaseTime),
    .cfgCycleTime(cfgCycleTime), .peerEvent(peerEvent),
    .gateOpen(gateOpen), .entryPulse(entryPulse),
    .cfgReject(cfgReject), .schedConflict(schedConflict)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // driver side of the scoreboard
  task automatic pushEvt(input logic [63:0] t, input logic [7:0] m);
    expQ.push_back('{t: t, m: m});
  endtask

  task automatic writeEntry(input logic [2:0] idx, input logic [7:0] m, input logic [31:0] ns);
    cfgWrEn = 1'b1; cfgWrIdx = idx; cfgWrMask = m; cfgWrInterval = ns;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic doCommit(input logic [3:0] cnt, input logic [63:0] base,
                          input logic [31:0] cyc, input logic expRej, input string req);
    cfgCommit = 1'b1; cfgNumEntries = cnt; cfgBaseTime = base; cfgCycleTime = cyc;
    @(negedge clk);
    check(req, "commit reject flag", 64'(cfgReject), 64'(expRej));
    cfgCommit = 1'b0;
  endtask

  task automatic waitTime(input logic [63:0] t);
    while (syncTime < t) @(negedge clk);
  endtask

  // monitor: time advance, scoreboard pop, hold and conflict checks
  initial begin
    forever begin
      @(negedge clk);
      if (monitorOn) begin
        hit = 1'b0;
        if (expQ.size() > 0 && expQ[0].t == syncTime) begin
          hit = 1'b1;
          check("R3", "entry pulse at scheduled slot", 64'(entryPulse), 64'd1);
          check("R4", "mask at entry start", 64'(gateOpen), 64'(expQ[0].m));
          curMask = expQ[0].m;
          void'(expQ.pop_front());
        end else begin
          check("R5", "no pulse between entry starts", 64'(entryPulse), 64'd0);
          check("R3", "mask held within entry", 64'(gateOpen), 64'(curMask));
        end
        check("R9", "conflict flag", 64'(schedConflict), 64'(conflictExp));
        peerEvent = (syncTime == peerA) || (syncTime == peerB);
        conflictExp = peerEvent && hit;
      end
      syncTime = syncTime + step;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "gates open in reset", 64'(gateOpen), 64'hFF);
    check("R1", "pulse low in reset", 64'(entryPulse), 64'd0);
    check("R1", "reject low in reset", 64'(cfgReject), 64'd0);
    check("R1", "conflict low in reset", 64'(schedConflict), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    monitorOn = 1'b1;

    // first list: class 7 for 1000 ns, classes 0..6 for 1900 ns (10 slots)
    writeEntry(3'd0, 8'h80, 32'd1000);
    writeEntry(3'd1, 8'h7F, 32'd1900);
    writeEntry(3'd2, 8'hFF, 32'd0);
    doCommit(4'd0, 64'd0, 32'd3000, 1'b1, "R6 count zero");
    doCommit(4'd2, 64'd0, 32'd2000, 1'b1, "R6 cycle mismatch");
    doCommit(4'd3, 64'd0, 32'd3000, 1'b1, "R6 zero interval");
    doCommit(4'd9, 64'd0, 32'd3000, 1'b1, "R6 count above max");
    check("R6", "gates untouched after rejects", 64'(gateOpen), 64'hFF);

    baseT = ((syncTime / 200) + 20) * 200;
    swapT = baseT + 64'd9000;
    for (int c = 0; c < 3; c++) begin
      pushEvt(baseT + 64'(c * 3000), 8'h80);
      pushEvt(baseT + 64'(c * 3000 + 1000), 8'h7F);
    end
    for (int c = 0; c < 5; c++) begin
      pushEvt(swapT + 64'(c * 1200), 8'h01);
      pushEvt(swapT + 64'(c * 1200 + 400), 8'h02);
      pushEvt(swapT + 64'(c * 1200 + 600), 8'h0C);
    end
    doCommit(4'd2, baseT, 32'd2900, 1'b0, "R3 rounded cycle accepted");

    waitTime(baseT - 64'd400);
    check("R2", "gates open before base", 64'(gateOpen), 64'hFF);
    check("R2", "no pulse before base", 64'(entryPulse), 64'd0);

    // second list staged while the first runs
    writeEntry(3'd0, 8'h01, 32'd400);
    writeEntry(3'd1, 8'h02, 32'd150);
    writeEntry(3'd2, 8'h0C, 32'd600);
    waitTime(baseT + 64'd6500);
    doCommit(4'd3, 64'd0, 32'd1200, 1'b0, "R7 mid-cycle commit accepted");
    writeEntry(3'd0, 8'hFF, 32'd200);
    doCommit(4'd3, 64'd0, 32'd1200, 1'b1, "R8 commit while pending");

    // finer time steps and peer events (one coincident, one not)
    waitTime(swapT + 64'd2400);
    step = 64'd100;
    peerA = swapT + 64'd2800;
    peerB = swapT + 64'd2900;

    waitTime(swapT + 64'd5800);
    check("R7", "all scheduled entries observed", 64'(expQ.size()), 64'd0);
    check("R10", "entries seen with sub-slot steps", 64'(curMask), 64'h0C);
    finishRun();
  end

endmodule